// File: doc/BRIEF.md
# Fetch Patch Remapper

This block sits on the instruction and literal fetch path between the flash array and the CPU. A small bank of word comparators is held in configuration registers. When the fetch address falls on a word that an enabled comparator holds, the word read from flash is replaced by a programmed substitute. The substitute reaches the output in the same cycle as the fetch. No cycles are added. Firmware uses the block to correct code in flash without rewriting flash. A debugger can also use it to steer execution.

The configuration registers are cleared only by the power-on reset. A system reset leaves them untouched. A patch programmed before a system reset therefore still applies to the first fetch of the next boot, including the fetch of the reset vector at address 0x00000004. That fetch selects where the next boot from flash begins.

A guard state machine is cleared by every system reset. It decides whether patching is allowed during the current boot. The machine has three states:
- GRD_BOOT: the cycles during system reset and up to the first clock edge after reset is released. In this state patching is allowed only while the lock condition is absent.
- GRD_OPEN: patching is allowed.
- GRD_SHUT: patching is forced off.

The lock condition is a non-zero protection level together with an indication that the previous boot came from SRAM. The transitions are:
- BOOT_TO_OPEN: taken when the lock condition is absent at the first clock edge after reset is released.
- BOOT_TO_SHUT: taken when the lock condition is present at that edge.
- OPEN_HOLD and SHUT_HOLD: each state stays as it is until the next system reset.
- ANY_TO_BOOT: any system reset or power-on reset returns the machine to GRD_BOOT.

Top module: `fpr_patch_remap`

## Requirements
- R1: Power-on reset (`por_n` low) clears every configuration register to zero. After it, every register reads 0 and no fetch is patched.
- R2: System reset (`rst_n` low with `por_n` high) leaves every configuration register unchanged. Writes are ignored while `rst_n` is low.
- R3: The fetch is patched when three things hold together: `fetch_valid` is 1, the global enable is 1, and an enabled slot's stored bits [31:2] equal `fetch_addr[31:2]`. When patched, `patch_hit` is 1 and `patch_rdata` carries that slot's substitute word in the same cycle. A fetch of a neighbouring word is not patched.
- R4: Fetch address bits [1:0] play no part in matching.
- R5: A slot whose enable bit (bit 0 of its comparator register) is 0 never matches. With no match, `patch_rdata` equals `flash_rdata` and `patch_hit` is 0.
- R6: With the global enable (bit 0 of register 0x0) at 0, no fetch is patched.
- R7: When several enabled slots match, the slot with the lowest index supplies the substitute word.
- R8: If `prot_level` is non-zero and `boot_sram` is 1 while in GRD_BOOT, patching stays off until the next system reset. The lock is captured at the first clock edge after reset is released. Later changes to either input do not lift it.
- R9: A patch on address 0x00000004 that is programmed before a system reset applies to the very first fetch after that reset is released.
- R10: With `fetch_valid` at 0, `patch_hit` is 0 and `patch_rdata` equals `flash_rdata`.
- R11: The register map is:
  - 0x0: control. Bit 0 is the global enable; every other bit reads 0.
  - 0x4 + k: comparator register of slot k. Bits [31:2] hold the word address, bit 0 is the slot enable, and bit 1 reads 0.
  - 0x8 + k: substitute word of slot k.

  Every other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the configuration |
| rst_n | input | 1 | System reset, active low; resets only the guard |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset for both read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| prot_level | input | 2 | Protection level; 0 means unprotected |
| boot_sram | input | 1 | 1 when the previous boot came from SRAM |
| fetch_valid | input | 1 | A fetch is being presented this cycle |
| fetch_addr | input | 32 | Byte address of the fetch |
| flash_rdata | input | 32 | Word read from flash |
| patch_rdata | output | 32 | Word delivered to the CPU |
| patch_hit | output | 1 | The word delivered is a substitute |

## Verification
Two functions can act in the same cycle: the guard's decision taken in GRD_BOOT, and the comparator match on the reset-vector fetch. The bench releases the system reset on a falling edge and presents the reset-vector fetch before the next rising edge. It judges that single cycle against the lock inputs. It then checks on the following cycles that the decision holds after the lock inputs are changed. Comparator behaviour is swept over every combination of slot, global enable, slot enable and low address bits. Priority is checked for every set of enabled slots that share one address.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [1:0] {
        GRD_BOOT = 2'd0,
        GRD_OPEN = 2'd1,
        GRD_SHUT = 2'd2
    } guard_state_e;

    localparam logic [1:0] GRP_CTRL = 2'b00;
    localparam logic [1:0] GRP_CMP  = 2'b01;
    localparam logic [1:0] GRP_REPL = 2'b10;

    function automatic logic lock_request(input logic [1:0] prot, input logic sram_boot);
        return (prot != 2'b00) && sram_boot;
    endfunction

endpackage

// File: rtl/fpr_guard_fsm.sv
module fpr_guard_fsm
    import fpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] prot_level,
    input  logic       boot_sram,
    output logic       patch_allow
);

    guard_state_e state_q;
    guard_state_e state_d;
    logic         lock_now;

    assign lock_now = lock_request(prot_level, boot_sram);

    // state register: any system reset returns to BOOT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GRD_BOOT;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        patch_allow = 1'b0;
        unique case (state_q)
            GRD_BOOT: begin
                patch_allow = !lock_now;
                state_d     = lock_now ? GRD_SHUT : GRD_OPEN;
            end
            GRD_OPEN: begin
                patch_allow = 1'b1;
                state_d     = GRD_OPEN;
            end
            GRD_SHUT: begin
                patch_allow = 1'b0;
                state_d     = GRD_SHUT;
            end
            default: begin
                patch_allow = 1'b0;
                state_d     = GRD_SHUT;
            end
        endcase
    end

    AST_BOOT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRD_BOOT) |=> (state_q != GRD_BOOT)); // R8
    AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRD_SHUT) |=> (state_q == GRD_SHUT)); // R8
    AST_LOCK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRD_BOOT && prot_level != 2'b00 && boot_sram) |=> (state_q == GRD_SHUT)); // R8

endmodule

// File: rtl/fpr_cfg_regs.sv
module fpr_cfg_regs
    import fpr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32
) (
    input  logic                                 clk,
    input  logic                                 por_n,
    input  logic                                 sys_rst_n,
    input  logic                                 wr_en,
    input  logic [3:0]                           addr,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [DATA_W-1:0]                    rdata,
    output logic                                 glob_en,
    output logic [NUM_SLOTS-1:0]                 slot_en,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:2]     slot_addr,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]     slot_repl
);

    localparam int IDX_W = 2;

    logic             wr_ok;
    logic [1:0]       grp;
    logic [IDX_W-1:0] idx;
    logic             unused_wbits;

    assign wr_ok        = wr_en && sys_rst_n;
    assign grp          = addr[3:2];
    assign idx          = addr[1:0];
    assign unused_wbits = wdata[1];

    // global enable: cleared only by power-on
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            glob_en <= 1'b0;
        else if (wr_ok && grp == GRP_CTRL && idx == '0)
            glob_en <= wdata[0];
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                slot_en[k]   <= 1'b0;
                slot_addr[k] <= '0;
            end else if (wr_ok && grp == GRP_CMP && idx == IDX_W'(k)) begin
                slot_en[k]   <= wdata[0];
                slot_addr[k] <= wdata[ADDR_W-1:2];
            end
        end

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                slot_repl[k] <= '0;
            else if (wr_ok && grp == GRP_REPL && idx == IDX_W'(k))
                slot_repl[k] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (grp)
            GRP_CTRL: if (idx == '0) rdata[0] = glob_en;
            GRP_CMP: begin
                if (int'(idx) < NUM_SLOTS) begin
                    rdata[ADDR_W-1:2] = slot_addr[idx];
                    rdata[0]          = slot_en[idx];
                end
            end
            GRP_REPL: if (int'(idx) < NUM_SLOTS) rdata = slot_repl[idx];
            default:  rdata = '0;
        endcase
    end

    AST_RESET_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> ($stable(glob_en) && $stable(slot_en) && $stable(slot_addr) && $stable(slot_repl))); // R2

endmodule

// File: rtl/fpr_match_bank.sv
module fpr_match_bank #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             allow,
    input  logic                             fetch_valid,
    input  logic [ADDR_W-1:2]                fetch_word,
    input  logic [NUM_SLOTS-1:0]             slot_en,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:2] slot_addr,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_repl,
    output logic                             hit,
    output logic [DATA_W-1:0]                repl_word
);

    logic [NUM_SLOTS-1:0] raw_match;
    logic [NUM_SLOTS-1:0] win_vec;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
        assign raw_match[k] = slot_en[k] && (slot_addr[k] == fetch_word);
    end

    // lowest index wins: scan from the top so the lowest overwrites
    always_comb begin
        win_vec   = '0;
        repl_word = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (raw_match[k]) begin
                win_vec   = '0;
                win_vec[k] = 1'b1;
                repl_word = slot_repl[k];
            end
        end
    end

    assign hit = allow && fetch_valid && (raw_match != '0);

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_vec)); // R7
    AST_WINNER_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vec & ~raw_match) == '0); // R7

endmodule

// File: rtl/fpr_patch_remap.sv
module fpr_patch_remap #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [1:0]        prot_level,
    input  logic              boot_sram,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic [DATA_W-1:0] patch_rdata,
    output logic              patch_hit
);

    logic                             glob_en;
    logic [NUM_SLOTS-1:0]             slot_en;
    logic [NUM_SLOTS-1:0][ADDR_W-1:2] slot_addr;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_repl;
    logic                             guard_allow;
    logic                             bank_hit;
    logic [DATA_W-1:0]                repl_word;
    logic [1:0]                       unused_lo;
    logic                             sys_rst_n;

    assign unused_lo = fetch_addr[1:0];
    assign sys_rst_n = rst_n && por_n;

    fpr_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_en     (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .glob_en   (glob_en),
        .slot_en   (slot_en),
        .slot_addr (slot_addr),
        .slot_repl (slot_repl)
    );

    fpr_guard_fsm u_guard (
        .clk         (clk),
        .rst_n       (sys_rst_n),
        .prot_level  (prot_level),
        .boot_sram   (boot_sram),
        .patch_allow (guard_allow)
    );

    fpr_match_bank #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk         (clk),
        .rst_n       (sys_rst_n),
        .allow       (guard_allow && glob_en),
        .fetch_valid (fetch_valid),
        .fetch_word  (fetch_addr[ADDR_W-1:2]),
        .slot_en     (slot_en),
        .slot_addr   (slot_addr),
        .slot_repl   (slot_repl),
        .hit         (bank_hit),
        .repl_word   (repl_word)
    );

    assign patch_hit   = bank_hit;
    assign patch_rdata = bank_hit ? repl_word : flash_rdata;

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !glob_en |-> !patch_hit); // R6
    AST_HIT_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!sys_rst_n)
        patch_hit |-> fetch_valid); // R10
    AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !guard_allow |-> !patch_hit); // R8

endmodule

// File: tb/fpr_patch_remap_bench.sv
module fpr_patch_remap_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  prot_level = '0;
    logic        boot_sram = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] flash_rdata = '0;
    logic [31:0] patch_rdata;
    logic        patch_hit;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpr_patch_remap u_fpr_patch_remap (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prot_level(prot_level),
        .boot_sram(boot_sram), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .flash_rdata(flash_rdata), .patch_rdata(patch_rdata), .patch_hit(patch_hit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1 check(tag, cfg_rdata, exp);
    endtask

    task automatic fetch_now(input string tag, input logic v, input logic [31:0] a,
                             input logic [31:0] fd, input logic exp_hit, input logic [31:0] exp_d);
        fetch_valid = v; fetch_addr = a; flash_rdata = fd;
        #1;
        check({tag, " hit"}, {31'b0, patch_hit}, {31'b0, exp_hit});
        check({tag, " data"}, patch_rdata, exp_d);
    endtask

    task automatic fetch_chk(input string tag, input logic v, input logic [31:0] a,
                             input logic [31:0] fd, input logic exp_hit, input logic [31:0] exp_d);
        @(negedge clk);
        fetch_now(tag, v, a, fd, exp_hit, exp_d);
    endtask

    task automatic sys_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_slots();
        for (int k = 0; k < 4; k++) wr(4'(4 + k), 32'h0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R1: cleared state after power-on
        for (int a = 0; a < 16; a++) rd_chk("R1 por readback", 4'(a), 32'h0);
        fetch_chk("R1 no patch after por", 1'b1, 32'h4, 32'h1234_5678, 1'b0, 32'h1234_5678);

        // R11: register map and unmapped offsets
        for (int a = 0; a < 16; a++) begin
            if ((a >= 1 && a <= 3) || a >= 12) begin
                wr(4'(a), 32'hFFFF_FFFF);
                rd_chk("R11 unmapped reads zero", 4'(a), 32'h0);
            end
        end
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk("R11 ctrl only bit0", 4'h0, 32'h1);
        wr(4'h5, 32'hFFFF_FFFF);
        rd_chk("R11 comparator bit1 zero", 4'h5, 32'hFFFF_FFFD);
        wr(4'h9, 32'hDEAD_BEEF);
        rd_chk("R11 substitute readback", 4'h9, 32'hDEAD_BEEF);
        clear_slots();

        // R3 R4 R5 R6: sweep slot, global enable, slot enable, low bits
        for (int k = 0; k < 4; k++) begin
            logic [31:0] base;
            base = 32'h0800_0100 + 32'(k * 16);
            clear_slots();
            wr(4'(8 + k), 32'hC0DE_0000 + 32'(k));
            for (int g = 0; g < 2; g++) begin
                for (int e = 0; e < 2; e++) begin
                    wr(4'h0, 32'(g));
                    wr(4'(4 + k), base | 32'(e));
                    for (int lo = 0; lo < 4; lo++) begin
                        logic exp_h;
                        logic [31:0] fd;
                        fd    = 32'h1111_0000 + 32'(lo);
                        exp_h = (g == 1) && (e == 1);
                        fetch_chk("R3 R4 R5 R6 sweep", 1'b1, base | 32'(lo), fd, exp_h,
                                  exp_h ? (32'hC0DE_0000 + 32'(k)) : fd);
                    end
                    fetch_chk("R3 neighbour word", 1'b1, base + 32'h4, 32'h2222_0000, 1'b0, 32'h2222_0000);
                end
            end
        end

        // R7: priority over every set of enabled slots on one address
        wr(4'h0, 32'h1);
        for (int k = 0; k < 4; k++) wr(4'(8 + k), 32'hD000_0000 + 32'(k));
        for (int m = 0; m < 16; m++) begin
            int win;
            win = -1;
            for (int k = 3; k >= 0; k--) if (m[k]) win = k;
            for (int k = 0; k < 4; k++) wr(4'(4 + k), 32'h0800_0200 | 32'(m[k]));
            fetch_chk("R7 priority", 1'b1, 32'h0800_0202, 32'h3333_3333, win >= 0,
                      win >= 0 ? (32'hD000_0000 + 32'(win)) : 32'h3333_3333);
        end

        // R10: no fetch, no patch
        fetch_chk("R10 fetch_valid low", 1'b0, 32'h0800_0200, 32'h4444_4444, 1'b0, 32'h4444_4444);

        // R9 R2: reset vector patch survives system reset
        clear_slots();
        wr(4'h4, 32'h0000_0005);
        wr(4'h8, 32'h2000_0101);
        sys_reset();
        fetch_now("R9 first fetch after reset", 1'b1, 32'h4, 32'h0800_0000, 1'b1, 32'h2000_0101);
        rd_chk("R2 ctrl kept", 4'h0, 32'h1);
        rd_chk("R2 comparator kept", 4'h4, 32'h0000_0005);
        rd_chk("R2 substitute kept", 4'h8, 32'h2000_0101);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'h8; cfg_wdata = 32'h5555_5555;
        @(negedge clk); cfg_we = 1'b0; rst_n = 1'b1;
        rd_chk("R2 write ignored in reset", 4'h8, 32'h2000_0101);

        // R8: lock when protected and previous boot from SRAM
        prot_level = 2'd1; boot_sram = 1'b1;
        sys_reset();
        fetch_now("R8 locked in boot cycle", 1'b1, 32'h4, 32'h0800_0000, 1'b0, 32'h0800_0000);
        @(negedge clk);
        prot_level = 2'd0; boot_sram = 1'b0;
        fetch_chk("R8 lock held after inputs drop", 1'b1, 32'h4, 32'h0800_0000, 1'b0, 32'h0800_0000);
        prot_level = 2'd2; boot_sram = 1'b0;
        sys_reset();
        fetch_now("R8 protected flash boot open", 1'b1, 32'h4, 32'h0800_0000, 1'b1, 32'h2000_0101);
        prot_level = 2'd0; boot_sram = 1'b1;
        sys_reset();
        fetch_now("R8 unprotected sram boot open", 1'b1, 32'h4, 32'h0800_0000, 1'b1, 32'h2000_0101);
        @(negedge clk); prot_level = 2'd3;
        fetch_chk("R8 open stays open", 1'b1, 32'h4, 32'h0800_0000, 1'b1, 32'h2000_0101);
        prot_level = 2'd0; boot_sram = 1'b0;

        // R1: power-on clears everything
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        for (int a = 0; a < 12; a++) rd_chk("R1 por clears", 4'(a), 32'h0);
        fetch_chk("R1 reset vector unpatched", 1'b1, 32'h4, 32'h0800_0000, 1'b0, 32'h0800_0000);

        done = 1;
        summary();
        $finish;
    end

endmodule